// File: doc/BRIEF.md
# Strap Resynchronization Write Sequencer

After a configuration loader has refreshed the strap-value registers, several control registers that take their reset values from those straps no longer match them. This block brings them back in line. On a start pulse it walks a fixed list of dependent registers and overwrites each one with a default word that arrives precomputed on its inputs. It acts as a write-only master on an internal register bus that has address, data, write and acknowledge signals.

The list covers the following registers:

- the advertisement and basic control registers of each physical PHY port;
- a one-cycle reset pulse for the PHY management interface;
- three virtual PHY registers;
- the port 1 MII basic control register;
- the LED configuration register;
- three manual flow control registers.

Every word is written whole, with no read-modify-write. The restart-negotiation bit is forced on in every basic control word that belongs to a PHY or to the virtual PHY.

When the external-MII flag is set at start, the writes to the port 1 PHY are left out. All other entries, including the port 1 MII register, are still written. A one-cycle done pulse marks the end of the run.

Top module: `strap_resync_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it falls, `bus_wr`, `mgmt_rst` and `done` are 0.
- R2: With default parameters the writes go out in this order and to these addresses:
  - PHY port 1 advertisement 0x110, then its basic control 0x100;
  - PHY port 2 advertisement 0x150, then its basic control 0x140;
  - the management reset pulse;
  - virtual PHY advertisement 0x310, special control/status 0x31C, then basic control 0x300;
  - port 1 MII basic control 0x380;
  - LED configuration 0x1BC;
  - flow control for ports 0, 1 and 2 at 0x1A0, 0x1A4 and 0x1A8.
- R3: The word written to each non-basic-control entry equals its supplied default in all 32 bits. This includes the port 1 MII basic control word. For port n, the PHY defaults are taken from bits [32n-1:32(n-1)] of `phy_adv_dflt` and `phy_bctl_dflt`. Flow control for port k is taken from bits [32k+31:32k] of `fc_dflt`.
- R4: The word written to each PHY basic control register and to the virtual PHY basic control register is its default with bit 9 (restart negotiation) set. All other bits are unchanged.
- R5: `ext_mii` is sampled in the start cycle. If it is 1, no write goes to 0x110 or 0x100, and every other entry is still written in the same order.
- R6: `mgmt_rst` is high for exactly one cycle per run. It comes after the last physical PHY write has been acknowledged and before the first virtual PHY write, and `bus_wr` is 0 in that cycle.
- R7: Only one write is outstanding at a time. `bus_addr`, `bus_wdata` and `bus_wr` stay unchanged until `bus_ack` is seen. An acknowledge that arrives while `bus_wr` is 0 has no effect.
- R8: A start pulse that arrives while a run is in progress is ignored. The run still makes exactly one pass, and no second pass follows.
- R9: `done` is high for exactly one cycle, in the cycle after the last write is acknowledged, with `bus_wr` at 0. The block is then idle.
- R10: Raising `rst` in the middle of a run stops it. `bus_wr` is 0 after the next edge, and no further writes or done follow until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| ext_mii | input | 1 | External MII mode selected; sampled with start |
| phy_adv_dflt | input | NUM_PHY*DATA_W | Advertisement defaults, port 1 in low word |
| phy_bctl_dflt | input | NUM_PHY*DATA_W | PHY basic control defaults, port 1 in low word |
| vphy_adv_dflt | input | DATA_W | Virtual PHY advertisement default |
| vphy_spc_dflt | input | DATA_W | Virtual PHY special control/status default |
| vphy_bctl_dflt | input | DATA_W | Virtual PHY basic control default |
| mii_bctl_dflt | input | DATA_W | Port 1 MII basic control default |
| led_dflt | input | DATA_W | LED configuration default |
| fc_dflt | input | 3*DATA_W | Flow control defaults, port 0 in low word |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | DATA_W | Write data |
| bus_wr | output | 1 | Write request, held until acknowledged |
| bus_ack | input | 1 | Write acknowledge from the register bus |
| mgmt_rst | output | 1 | One-cycle reset for the PHY management interface |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A step index or state that has gone wrong shows at the ports on the next acknowledged write, because the address or data will not match the expected list entry. An index that skips shows up either as a missing address in the log of writes or as `mgmt_rst` firing at the wrong write count. A lost acknowledge leaves `bus_wr` high indefinitely, and this is caught as a run that never reaches done. A handshake register that moves early changes the address or data while the slave is still holding off its acknowledge, and this is detected within one cycle.

// File: rtl/strap_resync_pkg.sv
package strap_resync_pkg;

   typedef enum logic [1:0] {
      K_WRITE = 2'd0,
      K_SKIP  = 2'd1,
      K_PULSE = 2'd2
   } step_kind_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOAD = 2'd1,
      S_WAIT = 2'd2
   } seq_state_t;

   // steps that follow the physical PHY block, relative to its end
   localparam int TAIL_PULSE = 0;
   localparam int TAIL_VADV  = 1;
   localparam int TAIL_VSPC  = 2;
   localparam int TAIL_VBCTL = 3;
   localparam int TAIL_MII   = 4;
   localparam int TAIL_LED   = 5;
   localparam int TAIL_FC0   = 6;
   localparam int NUM_FC     = 3;
   localparam int TAIL_STEPS = TAIL_FC0 + NUM_FC;

endpackage

// File: rtl/strap_resync_step_rom.sv
module strap_resync_step_rom
   import strap_resync_pkg::*;
#(
   parameter int ADDR_W         = 12,
   parameter int DATA_W         = 32,
   parameter int NUM_PHY        = 2,
   parameter int RST_AN_BIT     = 9,
   parameter int PHY_BASE       = 'h100,
   parameter int PHY_STRIDE     = 'h40,
   parameter int PHY_ADV_OFS    = 'h10,
   parameter int VPHY_BCTL_ADDR = 'h300,
   parameter int VPHY_ADV_ADDR  = 'h310,
   parameter int VPHY_SPC_ADDR  = 'h31C,
   parameter int MII_BCTL_ADDR  = 'h380,
   parameter int LED_ADDR       = 'h1BC,
   parameter int FC_BASE        = 'h1A0,
   parameter int FC_STRIDE      = 'h4,
   localparam int PHY_STEPS     = 2 * NUM_PHY,
   localparam int N_STEP        = PHY_STEPS + TAIL_STEPS,
   localparam int IDX_W         = $clog2(N_STEP + 1)
) (
   input  logic [IDX_W-1:0]          idx,
   input  logic                      ext_q,
   input  logic [NUM_PHY*DATA_W-1:0] phy_adv_dflt,
   input  logic [NUM_PHY*DATA_W-1:0] phy_bctl_dflt,
   input  logic [DATA_W-1:0]         vphy_adv_dflt,
   input  logic [DATA_W-1:0]         vphy_spc_dflt,
   input  logic [DATA_W-1:0]         vphy_bctl_dflt,
   input  logic [DATA_W-1:0]         mii_bctl_dflt,
   input  logic [DATA_W-1:0]         led_dflt,
   input  logic [NUM_FC*DATA_W-1:0]  fc_dflt,
   output step_kind_t                kind,
   output logic [ADDR_W-1:0]         addr,
   output logic [DATA_W-1:0]         data,
   output logic                      last
);

   localparam logic [DATA_W-1:0] AN_MASK = DATA_W'(1) << RST_AN_BIT;

   logic [NUM_PHY*ADDR_W-1:0] adv_a;
   logic [NUM_PHY*ADDR_W-1:0] bctl_a;
   logic [NUM_FC*ADDR_W-1:0]  fc_a;

   for (genvar g = 0; g < NUM_PHY; g++) begin : g_phy_addr
      assign bctl_a[g*ADDR_W +: ADDR_W] = ADDR_W'(PHY_BASE + g * PHY_STRIDE);
      assign adv_a[g*ADDR_W +: ADDR_W]  = ADDR_W'(PHY_BASE + g * PHY_STRIDE + PHY_ADV_OFS);
   end

   for (genvar g = 0; g < NUM_FC; g++) begin : g_fc_addr
      assign fc_a[g*ADDR_W +: ADDR_W] = ADDR_W'(FC_BASE + g * FC_STRIDE);
   end

   always_comb begin
      int i;
      int pi;
      int t;
      i    = int'(idx);
      pi   = i / 2;
      t    = i - PHY_STEPS;
      kind = K_WRITE;
      addr = '0;
      data = '0;
      if (i < PHY_STEPS) begin
         if (i % 2 == 0) begin
            addr = adv_a[pi*ADDR_W +: ADDR_W];
            data = phy_adv_dflt[pi*DATA_W +: DATA_W];
         end else begin
            addr = bctl_a[pi*ADDR_W +: ADDR_W];
            data = phy_bctl_dflt[pi*DATA_W +: DATA_W] | AN_MASK;
         end
         if (ext_q && pi == 0) kind = K_SKIP;
      end else begin
         case (t)
            TAIL_PULSE: kind = K_PULSE;
            TAIL_VADV: begin
               addr = ADDR_W'(VPHY_ADV_ADDR);
               data = vphy_adv_dflt;
            end
            TAIL_VSPC: begin
               addr = ADDR_W'(VPHY_SPC_ADDR);
               data = vphy_spc_dflt;
            end
            TAIL_VBCTL: begin
               addr = ADDR_W'(VPHY_BCTL_ADDR);
               data = vphy_bctl_dflt | AN_MASK;
            end
            TAIL_MII: begin
               addr = ADDR_W'(MII_BCTL_ADDR);
               data = mii_bctl_dflt;
            end
            TAIL_LED: begin
               addr = ADDR_W'(LED_ADDR);
               data = led_dflt;
            end
            default: begin
               if (t >= TAIL_FC0 && t < TAIL_STEPS) begin
                  addr = fc_a[(t-TAIL_FC0)*ADDR_W +: ADDR_W];
                  data = fc_dflt[(t-TAIL_FC0)*DATA_W +: DATA_W];
               end else begin
                  kind = K_SKIP;
               end
            end
         endcase
      end
   end

   assign last = (idx == IDX_W'(N_STEP - 1));

endmodule

// File: rtl/strap_resync_bus_port.sv
module strap_resync_bus_port #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ack,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              wr
);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr   <= 1'b0;
         addr <= '0;
         data <= '0;
      end else if (load && !wr) begin
         wr   <= 1'b1;
         addr <= addr_in;
         data <= data_in;
      end else if (wr && ack) begin
         wr <= 1'b0;
      end
   end

   // R7: request and payload frozen until acknowledged
   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
      wr && !ack |=> wr && $stable(addr) && $stable(data));

   // R7: an acknowledged request drops on the next edge
   a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
      wr && ack |=> !wr);

endmodule

// File: rtl/strap_resync_seq.sv
module strap_resync_seq
   import strap_resync_pkg::*;
#(
   parameter int ADDR_W         = 12,
   parameter int DATA_W         = 32,
   parameter int NUM_PHY        = 2,
   parameter int RST_AN_BIT     = 9,
   parameter int PHY_BASE       = 'h100,
   parameter int PHY_STRIDE     = 'h40,
   parameter int PHY_ADV_OFS    = 'h10,
   parameter int VPHY_BCTL_ADDR = 'h300,
   parameter int VPHY_ADV_ADDR  = 'h310,
   parameter int VPHY_SPC_ADDR  = 'h31C,
   parameter int MII_BCTL_ADDR  = 'h380,
   parameter int LED_ADDR       = 'h1BC,
   parameter int FC_BASE        = 'h1A0,
   parameter int FC_STRIDE      = 'h4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      start,
   input  logic                      ext_mii,
   input  logic [NUM_PHY*DATA_W-1:0] phy_adv_dflt,
   input  logic [NUM_PHY*DATA_W-1:0] phy_bctl_dflt,
   input  logic [DATA_W-1:0]         vphy_adv_dflt,
   input  logic [DATA_W-1:0]         vphy_spc_dflt,
   input  logic [DATA_W-1:0]         vphy_bctl_dflt,
   input  logic [DATA_W-1:0]         mii_bctl_dflt,
   input  logic [DATA_W-1:0]         led_dflt,
   input  logic [3*DATA_W-1:0]       fc_dflt,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [DATA_W-1:0]         bus_wdata,
   output logic                      bus_wr,
   input  logic                      bus_ack,
   output logic                      mgmt_rst,
   output logic                      done
);

   localparam int PHY_STEPS = 2 * NUM_PHY;
   localparam int N_STEP    = PHY_STEPS + TAIL_STEPS;
   localparam int IDX_W     = $clog2(N_STEP + 1);
   localparam logic [ADDR_W-1:0] P1_ADV  = ADDR_W'(PHY_BASE + PHY_ADV_OFS);
   localparam logic [ADDR_W-1:0] P1_BCTL = ADDR_W'(PHY_BASE);

   if (NUM_PHY < 1 || NUM_PHY > 8) begin : g_bad_phy_count
      $error("strap_resync_seq: NUM_PHY must lie in 1..8");
   end
   if (RST_AN_BIT < 0 || RST_AN_BIT >= DATA_W) begin : g_bad_an_bit
      $error("strap_resync_seq: RST_AN_BIT outside the data word");
   end
   if (ADDR_W < 1 || (1 << ADDR_W) <= VPHY_SPC_ADDR) begin : g_bad_addr_w
      $error("strap_resync_seq: ADDR_W too narrow for the address map");
   end

   seq_state_t         state;
   logic [IDX_W-1:0]   idx;
   logic               ext_q;
   step_kind_t         kind;
   logic [ADDR_W-1:0]  rom_addr;
   logic [DATA_W-1:0]  rom_data;
   logic               rom_last;
   logic               load;

   strap_resync_step_rom #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PHY(NUM_PHY), .RST_AN_BIT(RST_AN_BIT),
      .PHY_BASE(PHY_BASE), .PHY_STRIDE(PHY_STRIDE), .PHY_ADV_OFS(PHY_ADV_OFS),
      .VPHY_BCTL_ADDR(VPHY_BCTL_ADDR), .VPHY_ADV_ADDR(VPHY_ADV_ADDR),
      .VPHY_SPC_ADDR(VPHY_SPC_ADDR), .MII_BCTL_ADDR(MII_BCTL_ADDR),
      .LED_ADDR(LED_ADDR), .FC_BASE(FC_BASE), .FC_STRIDE(FC_STRIDE)
   ) u_rom (
      .idx(idx), .ext_q(ext_q),
      .phy_adv_dflt(phy_adv_dflt), .phy_bctl_dflt(phy_bctl_dflt),
      .vphy_adv_dflt(vphy_adv_dflt), .vphy_spc_dflt(vphy_spc_dflt),
      .vphy_bctl_dflt(vphy_bctl_dflt), .mii_bctl_dflt(mii_bctl_dflt),
      .led_dflt(led_dflt), .fc_dflt(fc_dflt),
      .kind(kind), .addr(rom_addr), .data(rom_data), .last(rom_last)
   );

   assign load = (state == S_LOAD) && (kind == K_WRITE);

   strap_resync_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk(clk), .rst(rst), .load(load), .addr_in(rom_addr), .data_in(rom_data),
      .ack(bus_ack), .addr(bus_addr), .data(bus_wdata), .wr(bus_wr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= S_IDLE;
         idx      <= '0;
         ext_q    <= 1'b0;
         done     <= 1'b0;
         mgmt_rst <= 1'b0;
      end else begin
         done     <= 1'b0;
         mgmt_rst <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               ext_q <= ext_mii;
               idx   <= '0;
               state <= S_LOAD;
            end
            S_LOAD: case (kind)
               K_SKIP:  idx <= idx + 1'b1;
               K_PULSE: begin
                  mgmt_rst <= 1'b1;
                  idx      <= idx + 1'b1;
               end
               default: state <= S_WAIT;
            endcase
            S_WAIT: if (bus_ack) begin
               if (rom_last) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= S_LOAD;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   logic is_bctl;
   always_comb begin
      is_bctl = (bus_addr == ADDR_W'(VPHY_BCTL_ADDR));
      for (int p = 0; p < NUM_PHY; p++)
         if (bus_addr == ADDR_W'(PHY_BASE + p * PHY_STRIDE)) is_bctl = 1'b1;
   end

   // R4: every basic control write carries the restart-negotiation bit
   a_r4_restart_bit: assert property (@(posedge clk) disable iff (rst)
      bus_wr && is_bctl |-> bus_wdata[RST_AN_BIT]);

   // R5: port 1 PHY untouched in external MII mode
   a_r5_skip_port1: assert property (@(posedge clk) disable iff (rst)
      bus_wr && ext_q |-> (bus_addr != P1_ADV) && (bus_addr != P1_BCTL));

   // R6: management reset never overlaps a write
   a_r6_pulse_quiet: assert property (@(posedge clk) disable iff (rst)
      mgmt_rst |-> !bus_wr);

   // R6: management reset is a single-cycle pulse
   a_r6_pulse_width: assert property (@(posedge clk) disable iff (rst)
      mgmt_rst |=> !mgmt_rst);

   // R9: done lasts one cycle and comes with the bus quiet
   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |-> !bus_wr ##1 !done);

   // R9: done only follows an acknowledged write
   a_r9_done_after_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(bus_wr && bus_ack));

endmodule

// File: tb/sim_strap_resync_seq.sv
`timescale 1ns/1ps
module sim_strap_resync_seq;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam logic [DW-1:0] AN = 32'h0000_0200;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic ext_mii = 1'b0;
   logic [2*DW-1:0] phy_adv_dflt;
   logic [2*DW-1:0] phy_bctl_dflt;
   logic [DW-1:0] vphy_adv_dflt, vphy_spc_dflt, vphy_bctl_dflt, mii_bctl_dflt, led_dflt;
   logic [3*DW-1:0] fc_dflt;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic bus_wr, mgmt_rst, done;
   logic ack_r = 1'b0;
   logic stray_ack = 1'b0;
   wire  bus_ack = ack_r | stray_ack;

   always #4 clk = ~clk;

   strap_resync_seq u0 (
      .clk(clk), .rst(rst), .start(start), .ext_mii(ext_mii),
      .phy_adv_dflt(phy_adv_dflt), .phy_bctl_dflt(phy_bctl_dflt),
      .vphy_adv_dflt(vphy_adv_dflt), .vphy_spc_dflt(vphy_spc_dflt),
      .vphy_bctl_dflt(vphy_bctl_dflt), .mii_bctl_dflt(mii_bctl_dflt),
      .led_dflt(led_dflt), .fc_dflt(fc_dflt),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_ack(bus_ack),
      .mgmt_rst(mgmt_rst), .done(done)
   );

   int nchk = 0;
   int nerr = 0;
   int lat = 0;

   // slave model and monitors, all at the falling edge
   logic [AW-1:0] log_a [32];
   logic [DW-1:0] log_d [32];
   int nlog, cnt, stab_err, npulse, pulse_pos, pulse_wr, ndone, done_pos, done_wide, done_wr;
   logic prev_done;
   logic [AW-1:0] p_a;
   logic [DW-1:0] p_d;

   always @(negedge clk) begin
      if (rst) begin
         nlog = 0; cnt = 0; stab_err = 0; npulse = 0; pulse_pos = -1; pulse_wr = 0;
         ndone = 0; done_pos = -1; done_wide = 0; done_wr = 0; prev_done = 1'b0; ack_r = 1'b0;
      end else begin
         if (mgmt_rst) begin npulse++; pulse_pos = nlog; pulse_wr = int'(bus_wr); end
         if (done) begin
            ndone++; done_pos = nlog; done_wr = int'(bus_wr);
            if (prev_done) done_wide = 1;
         end
         prev_done = done;
         if (ack_r) begin
            ack_r = 1'b0; cnt = 0;
         end else if (bus_wr) begin
            if (cnt > 0 && (bus_addr != p_a || bus_wdata != p_d)) stab_err++;
            p_a = bus_addr; p_d = bus_wdata;
            if (cnt >= lat) begin
               if (nlog < 32) begin log_a[nlog] = bus_addr; log_d[nlog] = bus_wdata; end
               nlog++; ack_r = 1'b1;
            end else cnt++;
         end
      end
   end

   logic [AW-1:0] exp_a [16];
   logic [DW-1:0] exp_d [16];
   int nexp, nphyw;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic add_exp(input logic [AW-1:0] a, input logic [DW-1:0] d);
      exp_a[nexp] = a; exp_d[nexp] = d; nexp++;
   endtask

   // R2/R3/R4/R5: expected list derived from the requirement text
   task automatic build_exp(input bit ext);
      nexp = 0;
      for (int p = 0; p < 2; p++) begin
         if (!(ext && p == 0)) begin
            add_exp(AW'('h110 + p * 'h40), phy_adv_dflt[p*DW +: DW]);
            add_exp(AW'('h100 + p * 'h40), phy_bctl_dflt[p*DW +: DW] | AN);
         end
      end
      nphyw = nexp;
      add_exp(12'h310, vphy_adv_dflt);
      add_exp(12'h31C, vphy_spc_dflt);
      add_exp(12'h300, vphy_bctl_dflt | AN);
      add_exp(12'h380, mii_bctl_dflt);
      add_exp(12'h1BC, led_dflt);
      for (int k = 0; k < 3; k++) add_exp(AW'('h1A0 + 4 * k), fc_dflt[k*DW +: DW]);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; start = 1'b0; stray_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 3000 && ndone == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_run(input string tag);
      chk(nlog == nexp, {tag, " R2 write count"}, nlog, nexp);
      for (int i = 0; i < nexp && i < nlog; i++) begin
         chk(log_a[i] == exp_a[i], {tag, " R2 address order"}, 32'(log_a[i]), 32'(exp_a[i]));
         chk(log_d[i] == exp_d[i], {tag, " R3/R4 word value"}, log_d[i], exp_d[i]);
      end
      chk(npulse == 1, {tag, " R6 pulse count"}, npulse, 1);
      chk(pulse_pos == nphyw, {tag, " R6 pulse position"}, pulse_pos, nphyw);
      chk(pulse_wr == 0, {tag, " R6 bus quiet at pulse"}, pulse_wr, 0);
      chk(ndone == 1 && done_wide == 0, {tag, " R9 single done"}, ndone, 1);
      chk(done_pos == nexp && done_wr == 0, {tag, " R9 done after last ack"}, done_pos, nexp);
      chk(stab_err == 0, {tag, " R7 held until ack"}, stab_err, 0);
   endtask

   task automatic t_reset_state();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(!bus_wr && !mgmt_rst && !done, "R1 outputs in reset", {bus_wr, mgmt_rst, done}, 0);
      rst = 1'b0; @(negedge clk);
      chk(!bus_wr && !mgmt_rst && !done, "R1 outputs after reset", {bus_wr, mgmt_rst, done}, 0);
   endtask

   task automatic t_normal(input int l);
      lat = l; ext_mii = 1'b0; do_reset(); build_exp(1'b0);
      pulse_start(); wait_done(); check_run($sformatf("normal lat%0d", l));
   endtask

   task automatic t_ext_mii();
      lat = 1; do_reset(); build_exp(1'b1);
      ext_mii = 1'b1; pulse_start(); ext_mii = 1'b0;
      wait_done(); check_run("R5 ext mii");
   endtask

   task automatic t_start_busy();
      lat = 2; ext_mii = 1'b0; do_reset(); build_exp(1'b0);
      pulse_start();
      for (int i = 0; i < 500 && nlog < 3; i++) @(negedge clk);
      ext_mii = 1'b1; pulse_start(); ext_mii = 1'b0;
      wait_done();
      check_run("R8 start while busy");
      repeat (40) @(negedge clk);
      chk(nlog == nexp && ndone == 1, "R8 no second pass", nlog, nexp);
   endtask

   task automatic t_stray_ack();
      lat = 0; ext_mii = 1'b0; do_reset(); build_exp(1'b0);
      stray_ack = 1'b1;
      repeat (3) @(negedge clk);
      chk(!bus_wr && !done && !mgmt_rst, "R7 stray ack while idle", {bus_wr, done, mgmt_rst}, 0);
      stray_ack = 1'b0;
      pulse_start(); wait_done(); check_run("R7 after stray ack");
   endtask

   task automatic t_reset_abort();
      lat = 2; ext_mii = 1'b0; do_reset();
      pulse_start();
      for (int i = 0; i < 500 && nlog < 5; i++) @(negedge clk);
      rst = 1'b1; @(negedge clk);
      chk(!bus_wr && !done && !mgmt_rst, "R10 bus released by reset", {bus_wr, done, mgmt_rst}, 0);
      @(negedge clk); rst = 1'b0;
      repeat (40) @(negedge clk);
      chk(nlog == 0 && ndone == 0 && npulse == 0, "R10 no activity after abort", nlog + ndone + npulse, 0);
   endtask

   initial begin
      bit timeout;
      timeout = 1'b0;
      phy_adv_dflt   = {32'h0000_05E1, 32'h8000_01E1};
      phy_bctl_dflt  = {32'h5A00_3100, 32'h0000_3300};
      vphy_adv_dflt  = 32'h0001_0DE1;
      vphy_spc_dflt  = 32'hC000_0087;
      vphy_bctl_dflt = 32'h0000_1000;
      mii_bctl_dflt  = 32'h0000_2100;
      led_dflt       = 32'h0700_0030;
      fc_dflt        = {32'h0000_0016, 32'h0003_0026, 32'h1000_0006};
      fork
         begin
            t_reset_state();
            t_normal(0);
            t_normal(3);
            t_ext_mii();
            t_start_busy();
            t_stray_ack();
            t_reset_abort();
         end
         begin
            repeat (100000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule